// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address-Wake Filtering

This block turns an asynchronous serial line into parallel characters. A free-running enable pulse at sixteen times the bit rate paces it. Each character is 7, 8 or 9 data bits long and may carry a parity bit that the block checks itself. The low eight data bits go to a parallel output with a one-cycle load strobe. The ninth bit, when the frame has one, goes to its own output. The block keeps sticky error flags for framing, parity and overrun, and a buffer-full flag that the consumer clears with a read strobe.

The block has an address-wake mode for multi-drop links. Once the mode is armed, the block discards characters until it sees one whose ninth bit is high. That character is delivered normally and disarms the mode. A loopback setting switches the receiver's input from the external pin to the internal transmitter output and forces nine-bit framing. After a framing error, a receiving indicator stays high and the receiver stays parked until the line returns high.

The controller has six states, named in the package:
- `ST_IDLE` goes to `ST_START` when the line is low.
- `ST_START` goes to `ST_DATA` when the mid-bit sample is low, or back to `ST_IDLE` when it is high.
- `ST_DATA` goes to `ST_PARITY` (parity on) or `ST_STOP` (parity off) after the last data bit.
- `ST_PARITY` goes to `ST_STOP` after its sample.
- `ST_STOP` goes to `ST_IDLE` on a high sample, or to `ST_BREAK` on a low one.
- `ST_BREAK` goes to `ST_IDLE` once the line is high.

Top module: `serial_rx_attn`

## Requirements
- R1: In idle, a low line starts a frame that is confirmed on the 8th sample tick. If the line is high at that tick, the frame is dropped: there is no load, and no flag changes.
- R2: Data bits are sampled once every 16 ticks after confirmation, least-significant bit first. The `len_sel` codes are: 0 = 8 bits, 1 = 7 bits, 2 = 9 bits, 3 = loopback with 9 bits.
- R3: In 7-bit frames, `rx_data[6:0]` holds the data and `rx_data[7]` reads 0.
- R4: In 9-bit frames, `rx_data` holds bits 0..7 and `rx_bit9` holds the ninth bit. In 7- and 8-bit frames, `rx_bit9` reads 0.
- R5: A delivered character pulses `rx_load` for one cycle and sets `buf_full`. `buf_read` clears `buf_full`, but a load in the same cycle wins.
- R6: If a character is delivered while `buf_full` is set and no read happens in that cycle, `err_overrun` is set. The new character replaces the old one.
- R7: With `par_en` set, one parity bit follows the data. With `par_odd` = 1 the count of ones in data plus parity must be odd; with `par_odd` = 0 it must be even. A mismatch sets `err_parity`.
- R8: A stop bit sampled low sets `err_frame` and raises `receiving`. No new frame starts until the line is high, and `receiving` falls once the line is high.
- R9: The error flags are sticky until an `err_clear` pulse clears all three.
- R10: An `attn_set` pulse raises `attn_active`. While it is high, a character whose ninth bit is 0 (this includes every 7- or 8-bit character) gives no load, no `buf_full`, no parity error and no overrun. A framing error is still reported.
- R11: While `attn_active` is high, a character whose ninth bit is 1 is delivered normally and clears `attn_active`.
- R12: In loopback, the receiver reads `loop_line` and ignores `line_pin`.
- R13: After reset, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| line_pin | input | 1 | External serial line |
| loop_line | input | 1 | Internal transmitter output for loopback |
| len_sel | input | 2 | Frame length / loopback select |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| attn_set | input | 1 | Pulse to arm address-wake mode |
| buf_read | input | 1 | Pulse marking the character as read |
| err_clear | input | 1 | Pulse clearing the error flags |
| rx_data | output | 8 | Received character, low eight bits |
| rx_bit9 | output | 1 | Ninth received data bit |
| rx_load | output | 1 | One-cycle strobe on delivery |
| buf_full | output | 1 | Unread character present |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| attn_active | output | 1 | Address-wake mode armed |
| receiving | output | 1 | High after a framing error until the line is high |

## Verification
The bench builds the block with its default parameters: 16x oversampling, eight-bit data (which gives 7-, 8- and 9-bit frames) and a two-stage synchronizer. It supplies a tick every four clocks, so one bit lasts 64 clocks. With these values, frames of up to twelve bit times run back to back, and the mid-bit sampling point lands well inside each bit despite the synchronizer delay. The same setting also exercises a start pulse shorter than half a bit and a stop bit held low into a break.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        LEN_EIGHT = 2'b00,
        LEN_SEVEN = 2'b01,
        LEN_NINE  = 2'b10,
        LEN_LOOP  = 2'b11
    } rx_len_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } rx_state_e;

endpackage

// File: rtl/rx_line_front.sv
module rx_line_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_sel,
    input  logic line_pin,
    input  logic loop_line,
    output logic line_s
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   raw;

    assign raw = loop_sel ? loop_line : line_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw};
    end

    assign line_s = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_s,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W:0]   frame_data,
    output logic              frame_nine,
    output logic              par_bad,
    output logic              stop_bad
);
    localparam int NB = DATA_W + 1;
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(NB + 1);
    localparam logic [CW-1:0] MID_LAST  = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);

    rx_state_e      state_q, state_d;
    logic [CW-1:0]  tcnt_q;
    logic [BW-1:0]  bidx_q, nbits_q;
    logic [NB-1:0]  shift_q;
    logic           nine_q, pen_q, podd_q, pbit_q;
    logic           at_sample, arm;

    function automatic logic [BW-1:0] len_bits(input logic [1:0] sel);
        unique case (rx_len_e'(sel))
            LEN_SEVEN: return BW'(DATA_W - 1);
            LEN_EIGHT: return BW'(DATA_W);
            default:   return BW'(DATA_W + 1);
        endcase
    endfunction

    assign at_sample = tick && (tcnt_q == ((state_q == ST_START) ? MID_LAST : FULL_LAST));
    assign arm       = (state_q == ST_IDLE) && !line_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!line_s) state_d = ST_START;
            ST_START:  if (at_sample) state_d = line_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_sample && bidx_q == nbits_q - 1'b1)
                           state_d = pen_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_sample) state_d = ST_STOP;
            ST_STOP:   if (at_sample) state_d = line_s ? ST_IDLE : ST_BREAK;
            ST_BREAK:  if (line_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q   <= '0;
            bidx_q   <= '0;
            nbits_q  <= BW'(DATA_W);
            shift_q  <= '0;
            nine_q   <= 1'b0;
            pen_q    <= 1'b0;
            podd_q   <= 1'b0;
            pbit_q   <= 1'b0;
            done     <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE || state_q == ST_BREAK) tcnt_q <= '0;
            else if (tick) tcnt_q <= at_sample ? '0 : tcnt_q + 1'b1;
            if (arm) begin
                nbits_q <= len_bits(len_sel);
                nine_q  <= len_sel[1];
                pen_q   <= par_en;
                podd_q  <= par_odd;
                shift_q <= '0;
                bidx_q  <= '0;
            end
            if (state_q == ST_DATA && at_sample) begin
                for (int i = 0; i < NB; i++)
                    if (bidx_q == BW'(i)) shift_q[i] <= line_s;
                bidx_q <= bidx_q + 1'b1;
            end
            if (state_q == ST_PARITY && at_sample) pbit_q <= line_s;
            if (state_q == ST_STOP && at_sample) begin
                done     <= 1'b1;
                stop_bad <= !line_s;
                par_bad  <= pen_q && ((^shift_q) ^ pbit_q ^ podd_q);
            end
        end
    end

    assign frame_data = shift_q;
    assign frame_nine = nine_q;

    // R1: a high line at the confirming tick abandons the frame
    assert_glitch_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && tick && tcnt_q == MID_LAST && line_s) |=> state_q == ST_IDLE);

    // R8: no new frame while the line stays low after a framing error
    assert_break_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BREAK && !line_s) |=> state_q == ST_BREAK);

    // R3: short frames never fill the top data bit
    assert_short_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nbits_q == BW'(DATA_W - 1)) |-> !shift_q[DATA_W-1]);
endmodule

// File: rtl/rx_char_store.sv
module rx_char_store #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W:0]   frame_data,
    input  logic              frame_nine,
    input  logic              par_bad,
    input  logic              stop_bad,
    input  logic              line_s,
    input  logic              buf_read,
    input  logic              err_clear,
    input  logic              attn_set,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_load,
    output logic              buf_full,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              attn_active,
    output logic              receiving
);
    logic ninth, take;

    assign ninth = frame_nine && frame_data[DATA_W];
    assign take  = done && !(attn_active && !ninth);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_bit9     <= 1'b0;
            rx_load     <= 1'b0;
            buf_full    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
            attn_active <= 1'b0;
            receiving   <= 1'b0;
        end else begin
            rx_load <= take;
            if (take) begin
                rx_data <= frame_data[DATA_W-1:0];
                rx_bit9 <= ninth;
            end
            if (take)          buf_full <= 1'b1;
            else if (buf_read) buf_full <= 1'b0;

            if (take && buf_full && !buf_read) err_overrun <= 1'b1;
            else if (err_clear)                err_overrun <= 1'b0;
            if (take && par_bad)               err_parity  <= 1'b1;
            else if (err_clear)                err_parity  <= 1'b0;
            if (done && stop_bad)              err_frame   <= 1'b1;
            else if (err_clear)                err_frame   <= 1'b0;

            if (attn_set)                        attn_active <= 1'b1;
            else if (take && ninth && attn_active) attn_active <= 1'b0;

            if (done && stop_bad) receiving <= 1'b1;
            else if (line_s)      receiving <= 1'b0;
        end
    end

    // R5: a load always leaves the buffer marked full
    assert_full_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |-> buf_full);

    // R5: a read with no competing delivery empties the buffer
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_read && !done) |=> !buf_full);

    // R6: delivery onto an unread buffer flags overrun
    assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !attn_active && buf_full && !buf_read) |=> err_overrun);

    // R10: filtered characters never strobe a load
    assert_filter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && attn_active && !(frame_nine && frame_data[DATA_W])) |=> !rx_load);

    // R11: wake character loads and disarms
    assert_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && attn_active && frame_nine && frame_data[DATA_W] && !attn_set)
        |=> (rx_load && !attn_active));

    // R8: indicator drops once the line is high
    assert_rcv_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (receiving && line_s && !done) |=> !receiving);
endmodule

// File: rtl/serial_rx_attn.sv
module serial_rx_attn
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              line_pin,
    input  logic              loop_line,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              attn_set,
    input  logic              buf_read,
    input  logic              err_clear,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_load,
    output logic              buf_full,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              attn_active,
    output logic              receiving
);
    logic            line_s, done, frame_nine, par_bad, stop_bad;
    logic [DATA_W:0] frame_data;

    rx_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_sel  (rx_len_e'(len_sel) == LEN_LOOP),
        .line_pin  (line_pin),
        .loop_line (loop_line),
        .line_s    (line_s)
    );

    rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .line_s     (line_s),
        .len_sel    (len_sel),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .done       (done),
        .frame_data (frame_data),
        .frame_nine (frame_nine),
        .par_bad    (par_bad),
        .stop_bad   (stop_bad)
    );

    rx_char_store #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .frame_data  (frame_data),
        .frame_nine  (frame_nine),
        .par_bad     (par_bad),
        .stop_bad    (stop_bad),
        .line_s      (line_s),
        .buf_read    (buf_read),
        .err_clear   (err_clear),
        .attn_set    (attn_set),
        .rx_data     (rx_data),
        .rx_bit9     (rx_bit9),
        .rx_load     (rx_load),
        .buf_full    (buf_full),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_overrun (err_overrun),
        .attn_active (attn_active),
        .receiving   (receiving)
    );
endmodule

// File: tb/serial_rx_attn_bench.sv
module serial_rx_attn_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLKS   = 16 * TICK_DIV;

    logic       clk = 0, rst_n = 0, tick16 = 0, line_pin = 1, loop_line = 1;
    logic [1:0] len_sel = 0;
    logic       par_en = 0, par_odd = 0, attn_set = 0, buf_read = 0, err_clear = 0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_load, buf_full, err_frame, err_parity, err_overrun;
    logic       attn_active, receiving;

    int checks = 0, fails = 0, loads_seen = 0, exp_loads = 0;
    logic [7:0] exp_data = 0;
    logic exp_bit9 = 0, exp_full = 0, exp_fe = 0, exp_pe = 0, exp_oe = 0, exp_attn = 0;

    serial_rx_attn u_serial_rx_attn (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_pin(line_pin),
        .loop_line(loop_line), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
        .attn_set(attn_set), .buf_read(buf_read), .err_clear(err_clear),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_load(rx_load), .buf_full(buf_full),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
        .attn_active(attn_active), .receiving(receiving)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tick16 = (tc == TICK_DIV - 1);
            tc = (tc == TICK_DIV - 1) ? 0 : tc + 1;
        end
    end

    initial forever begin
        @(negedge clk);
        if (rx_load) loads_seen++;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_line(bit loop, logic v);
        if (loop) loop_line = v; else line_pin = v;
    endtask

    task automatic hold_bit(bit loop, logic v);
        set_line(loop, v);
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1;
        @(negedge clk); sig = 0;
    endtask

    function automatic int len_of(logic [1:0] sel);
        return (sel == 2'd1) ? 7 : (sel == 2'd0) ? 8 : 9;
    endfunction

    // expected effect of a frame, built from R3..R11
    task automatic model(int n, logic [8:0] d, bit pen, bit flip, bit bad_stop);
        logic ninth = (n == 9) && d[8];
        if (bad_stop) exp_fe = 1;
        if (!(exp_attn && !ninth)) begin
            exp_loads++;
            if (exp_full) exp_oe = 1;
            exp_full = 1;
            exp_data = (n == 7) ? {1'b0, d[6:0]} : d[7:0];
            exp_bit9 = ninth;
            if (pen && flip) exp_pe = 1;
            if (exp_attn && ninth) exp_attn = 0;
        end
    endtask

    task automatic send(logic [8:0] d, bit flip, bit bad_stop, bit loop);
        int n = len_of(len_sel);
        logic p = par_odd;
        hold_bit(loop, 1'b0);
        for (int i = 0; i < n; i++) begin
            p ^= d[i];
            hold_bit(loop, d[i]);
        end
        if (par_en) hold_bit(loop, p ^ flip);
        model(n, d, par_en, flip, bad_stop);
        if (bad_stop) begin
            hold_bit(loop, 1'b0);
            hold_bit(loop, 1'b0);
            chk("R8 receiving after bad stop", receiving, 1);
            set_line(loop, 1'b1);
            repeat (8) @(negedge clk);
            chk("R8 receiving released", receiving, 0);
        end else begin
            hold_bit(loop, 1'b1);
        end
        hold_bit(loop, 1'b1);
    endtask

    task automatic check_all(string tag);
        chk({tag, " R2 data"}, rx_data, exp_data);
        chk({tag, " R4 bit9"}, rx_bit9, exp_bit9);
        chk({tag, " R5 full"}, buf_full, exp_full);
        chk({tag, " R5 loads"}, loads_seen, exp_loads);
        chk({tag, " R8 frame"}, err_frame, exp_fe);
        chk({tag, " R7 parity"}, err_parity, exp_pe);
        chk({tag, " R6 overrun"}, err_overrun, exp_oe);
        chk({tag, " R10 attn"}, attn_active, exp_attn);
    endtask

    task automatic do_read();  pulse(buf_read);  exp_full = 0; endtask
    task automatic do_clear(); pulse(err_clear); exp_fe = 0; exp_pe = 0; exp_oe = 0; endtask
    task automatic do_attn();  pulse(attn_set);  exp_attn = 1; endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 data", rx_data, 0);
        chk("R13 flags", {rx_bit9, rx_load, buf_full, err_frame, err_parity,
                          err_overrun, attn_active, receiving}, 0);

        len_sel = 0; send(9'h0A5, 0, 0, 0); check_all("8-bit");
        // R3: bit 7 offered but never sent; no read so R6 overrun fires
        len_sel = 1; send(9'h0FF, 0, 0, 0); check_all("R3 7-bit");
        do_clear(); do_read(); check_all("R9 cleared");
        len_sel = 2; send(9'h13C, 0, 0, 0); check_all("R4 9-bit");
        do_read();
        len_sel = 0; par_en = 1; par_odd = 0; send(9'h033, 0, 0, 0); check_all("R7 even ok");
        do_read();
        par_odd = 1; send(9'h071, 1, 0, 0); check_all("R7 odd bad");
        do_read(); do_clear(); par_en = 0;
        send(9'h05A, 0, 1, 0); check_all("R8 framing");
        do_clear(); do_read(); check_all("R9 clear");
        // R1 glitch: start shorter than half a bit
        line_pin = 0; repeat (12) @(negedge clk); line_pin = 1;
        repeat (2 * BIT_CLKS) @(negedge clk); check_all("R1 glitch");
        // R10 / R11 address wake
        do_attn(); send(9'h011, 0, 0, 0); check_all("R10 8-bit filtered");
        len_sel = 2; par_en = 1; send(9'h022, 1, 0, 0); check_all("R10 9-bit low filtered");
        send(9'h1C3, 0, 0, 0); check_all("R11 wake");
        do_read(); par_en = 0;
        // R12 loopback with pin held low
        len_sel = 3; line_pin = 0;
        send(9'h1E7, 0, 0, 1); check_all("R12 loopback");
        line_pin = 1; repeat (4) @(negedge clk); len_sel = 0;
        do_read(); do_clear();

        for (int k = 0; k < 40; k++) begin
            len_sel = 2'($urandom_range(0, 2));
            par_en = 1'($urandom_range(0, 1));
            par_odd = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) do_read();
            if ($urandom_range(0, 3) == 0) do_clear();
            if ($urandom_range(0, 5) == 0) do_attn();
            send(9'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 9) == 0, 0);
            check_all("random");
        end

        summary();
        $finish;
    end
endmodule